// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Software-Cleared Done Flag

This block is the send side of a byte-oriented asynchronous serial port. A write strobe on the buffer port loads a byte, and the block frames it on the serial line: a low start slot, eight data slots with the least significant bit first, and one high stop slot. Each slot lasts one period of an external bit-rate tick. The line rests high whenever no frame is in flight.

A done flag tells the host that the line is free for the next byte. The flag goes high on the same clock edge that starts the stop slot. The frame is not complete at that point. The hardware never lowers the flag. Only a host write with value 0 on the flag port clears it. If the host writes a new byte while a frame is still going out, the rest of that frame is dropped. The line goes back to idle at once, and the new byte is framed from the next tick.

Top module: `ser_tx_top`

## Requirements
- R1: After reset, and at any time with no byte written, `txd_o` is 1 and `done_o` is 0, even while ticks keep arriving.
- R2: A frame for a byte written with `buf_wr_i` begins on the first `bit_tick_i` that comes after the write cycle.
- R3: A frame is 10 slots, each lasting exactly one tick period: a start slot at 0, the 8 data bits with bit 0 first, and a stop slot at 1.
- R4: `done_o` goes from 0 to 1 on the same clock edge on which the line enters the stop slot, and never before that edge.
- R5: Once set, `done_o` stays at 1 until a flag write with value 0. A flag write with value 1 never sets it.
- R6: A flag write with value 0 clears `done_o` on the next clock edge, provided the stop slot does not begin on that same edge.
- R7: A buffer write during a frame abandons that frame. On the next cycle the line is 1, the abandoned frame never raises `done_o`, and the new byte is framed starting at the next tick.
- R8: When the stop slot begins on the same edge as a flag write with value 0, the hardware set wins and `done_o` reads 1.
- R9: A buffer write in the same cycle as a tick does not start on that tick. The start slot begins one full tick period later.
- R10: When the stop slot has lasted one tick period, the line stays at 1 until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse, one per serial bit period |
| buf_wr_i | input | 1 | Buffer write strobe; starts a new frame |
| buf_data_i | input | 8 | Byte to send |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_val_i | input | 1 | Value written to the flag (only 0 has an effect) |
| txd_o | output | 1 | Serial line, idles at 1 |
| done_o | output | 1 | Done flag, set by hardware at the start of the stop slot |

## Verification
Two events can land on the same edge: the hardware setting the flag as the stop slot begins, and the host clearing the flag. The bench lines the two up by asserting the clearing flag write on the last cycle of bit 7, so it lands on the tick edge that opens the stop slot. It then requires the flag to read 1 (R8). A buffer write that coincides with a tick is the other same-cycle case. The bench aligns the strobe with a tick and requires the start slot to appear exactly one tick period later (R9).

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_START,
    SLOT_DATA,
    SLOT_STOP
  } slot_e;

  function automatic int unsigned frame_slots(input int unsigned data_w);
    return data_w + 2;
  endfunction

endpackage

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  load_i,
  output slot_e slot_o,
  output logic  shift_o,
  output logic  stop_enter_o
);

  localparam int unsigned SLOTS = frame_slots(DATA_W);
  localparam int unsigned CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(SLOTS - 2);

  logic             pend_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  // a load abandons any frame in flight; framing resumes on the next tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (pend_q) begin
        pend_q <= 1'b0;
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST_SLOT) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!busy_q)                slot_o = SLOT_IDLE;
    else if (cnt_q == '0)       slot_o = SLOT_START;
    else if (cnt_q == LAST_SLOT) slot_o = SLOT_STOP;
    else                        slot_o = SLOT_DATA;
  end

  assign shift_o      = tick_i && !load_i && (slot_o == SLOT_DATA);
  assign stop_enter_o = tick_i && !load_i && busy_q && (cnt_q == LAST_DATA);

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o
);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {1'b1, sh_q[DATA_W-1:1]};
  end

  assign bit_o = sh_q[0];

endmodule

// File: rtl/ser_tx_flag.sv
module ser_tx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  // hardware set outranks a software clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic              flag_wr_i,
  input  logic              flag_val_i,
  output logic              txd_o,
  output logic              done_o
);

  slot_e slot;
  logic  shift;
  logic  stop_enter;
  logic  data_bit;

  ser_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (bit_tick_i),
    .load_i      (buf_wr_i),
    .slot_o      (slot),
    .shift_o     (shift),
    .stop_enter_o(stop_enter)
  );

  ser_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (buf_wr_i),
    .data_i (buf_data_i),
    .shift_i(shift),
    .bit_o  (data_bit)
  );

  ser_tx_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (stop_enter),
    .clr_i (flag_wr_i && !flag_val_i),
    .flag_o(done_o)
  );

  always_comb begin
    unique case (slot)
      SLOT_START: txd_o = 1'b0;
      SLOT_DATA:  txd_o = data_bit;
      default:    txd_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic buf_wr_i,
  input logic flag_wr_i,
  input logic flag_val_i,
  input logic txd_o,
  input logic done_o
);

  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick_i && !buf_wr_i) |=> $stable(txd_o)); // R3

  AST_DONE_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> txd_o); // R4

  AST_DONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(flag_wr_i && !flag_val_i)) |=> done_o); // R5

  AST_DONE_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !bit_tick_i) |=> !done_o); // R5

  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr_i && !flag_val_i && !bit_tick_i) |=> !done_o); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_i |=> txd_o); // R7

  AST_ABORT_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_wr_i && !done_o) |=> !done_o); // R7

endmodule

bind ser_tx_top ser_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_tick_i(bit_tick_i),
  .buf_wr_i  (buf_wr_i),
  .flag_wr_i (flag_wr_i),
  .flag_val_i(flag_val_i),
  .txd_o     (txd_o),
  .done_o    (done_o)
);

// File: tb/ser_tx_top_test.sv
`timescale 1ns/1ps
module ser_tx_top_test;

  localparam int TPER = 8;
  localparam logic [7:0] VEC [6] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_data = 8'h00;
  logic       flag_wr = 1'b0;
  logic       flag_val = 1'b0;
  logic       txd;
  logic       done;
  logic [2:0] tdiv = 3'd0;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) tdiv <= tdiv + 3'd1;
  assign tick = (tdiv == 3'd7);

  ser_tx_top uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bit_tick_i(tick),
    .buf_wr_i  (buf_wr),
    .buf_data_i(buf_data),
    .flag_wr_i (flag_wr),
    .flag_val_i(flag_val),
    .txd_o     (txd),
    .done_o    (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    buf_wr = 1'b1;
    buf_data = b;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic write_flag(input logic v);
    @(negedge clk);
    flag_wr = 1'b1;
    flag_val = v;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  // waits for the start slot, then decodes one frame at mid-slot points
  task automatic decode(input logic [7:0] exp, input bit clash, output int waited);
    logic [7:0] got;
    got = 8'h00;
    waited = 0;
    while (txd === 1'b1 && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    for (int k = 1; k < 10 * TPER; k++) begin
      @(negedge clk);
      if (clash && k == 9 * TPER - 1) begin
        flag_wr = 1'b1;
        flag_val = 1'b0;
      end
      if (clash && k == 9 * TPER) flag_wr = 1'b0;
      if (k % TPER == TPER / 2) begin
        if (k / TPER == 0) chk("R3 start slot", int'(txd), 0);
        else if (k / TPER == 9) chk("R3 stop slot", int'(txd), 1);
        else got[k / TPER - 1] = txd;
      end
      if (k == 9 * TPER - 1) chk("R4 flag low before stop", int'(done), 0);
      if (k == 9 * TPER) begin
        chk(clash ? "R8 set beats clear" : "R4 flag at stop entry", int'(done), 1);
        chk("R4 line in stop", int'(txd), 1);
      end
    end
    chk("R3 byte lsb first", int'(got), int'(exp));
    @(negedge clk);
    chk("R10 idle after stop", int'(txd), 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (4) @(negedge clk);
    chk("R1 reset line", int'(txd), 1);
    chk("R1 reset flag", int'(done), 0);
    rst_n = 1'b1;
    begin
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (txd !== 1'b1 || done !== 1'b0) bad++;
      end
      chk("R1 idle under ticks", bad, 0);
    end

    foreach (VEC[i]) begin
      write_flag(1'b0);
      chk("R6 flag cleared", int'(done), 0);
      write_byte(VEC[i]);
      decode(VEC[i], 1'b0, w);
      chk("R2 start within one tick", int'(w <= TPER && w >= 1), 1);
    end

    // flag persistence and write-1 behaviour
    repeat (40) @(negedge clk);
    chk("R5 flag held", int'(done), 1);
    write_flag(1'b1);
    chk("R5 write 1 keeps set", int'(done), 1);
    write_flag(1'b0);
    chk("R6 clear next cycle", int'(done), 0);
    write_flag(1'b1);
    chk("R5 write 1 cannot set", int'(done), 0);

    // abort mid frame
    write_byte(8'h00);
    while (txd === 1'b1) @(negedge clk);
    repeat (3 * TPER + 4) @(negedge clk);
    chk("R7 pre-abort line low", int'(txd), 0);
    write_byte(8'hC6);
    chk("R7 line idle after abort", int'(txd), 1);
    chk("R7 no flag for dropped frame", int'(done), 0);
    decode(8'hC6, 1'b0, w);

    // same-edge set and clear
    write_flag(1'b0);
    write_byte(8'h5A);
    decode(8'h5A, 1'b1, w);
    chk("R8 flag still set later", int'(done), 1);

    // write coinciding with a tick
    write_flag(1'b0);
    repeat (3) @(negedge clk);
    while (tick !== 1'b1) @(negedge clk);
    buf_wr = 1'b1;
    buf_data = 8'h96;
    @(negedge clk);
    buf_wr = 1'b0;
    decode(8'h96, 1'b0, w);
    chk("R9 start one full tick later", w, TPER);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule